// File: doc/BRIEF.md
# Fixed-Length Packet Assembler with Address Filter

This block sits between a radio byte codec and a message dispatch stage. In receive it collects the byte stream coming up from the codec into frames of a fixed number of bytes, storing each byte in a packet buffer. Once the final byte of a frame lands, it compares the frame's destination field with a local address. If they match, or if the frame is addressed to everyone, it raises a one-cycle strobe together with the frame's handler identifier. No read request is needed: the frame is pushed upward as soon as it is complete, and the dispatch stage can then read the payload out of the buffer by index.

In transmit a client fills the same buffer through a write port and issues a send request. The request is answered on the next cycle with a pass or fail status and never stalls. The block then hands bytes to the codec one at a time. It presents each byte only after the codec has reported that the previous byte has gone out. After the last byte it raises a completion strobe carrying a success flag.

A single buffer serves both directions. For that reason, received bytes are dropped for as long as a transmission is running. A partial frame that stalls is discarded after a programmable number of bit-timer ticks.

Top module: `pkt_framer`

## Requirements
- R1: After reset, pkt_valid, send_ack, tx_valid and tx_done are all low.
- R2: Each accepted receive byte is stored at the next buffer index, starting at index 0. When the transmitter is idle, rd_data returns the byte at rd_idx one cycle after rd_idx is applied.
- R3: Byte 0 of a frame is the high byte of the destination and byte 1 is the low byte. When the PKT_LEN-th byte is accepted and the destination equals local_addr, pkt_valid pulses for one cycle in the next cycle, and pkt_handler then holds byte 2 of the frame.
- R4: A destination of 0xFFFF is always accepted. Any other mismatching destination produces no pkt_valid, and the next byte starts a new frame at index 0.
- R5: Each send_req cycle is answered in the next cycle by a one-cycle send_ack. send_ok is 1 only if the transmitter was idle, no receive frame was partly collected, and rx_valid was low in the request cycle.
- R6: After an accepted send, buffer bytes 0 to PKT_LEN-1 are presented in order on tx_byte, each with a one-cycle tx_valid pulse. The first byte appears two cycles after send_ack. Each later byte appears only after tx_byte_done has been seen for the previous byte.
- R7: The cycle after tx_byte_done is seen for the last byte, tx_done pulses for one cycle with tx_success high.
- R8: While a transmission is active, rx_valid is ignored. The buffer is left unchanged, no frame is reported, and the receive index stays at 0.
- R9: When tmo_ticks is nonzero and a frame is partly collected, the partial frame is discarded if tmo_ticks bit_tick pulses pass with no byte accepted. Fewer ticks than that keep it. When tmo_ticks is zero, no timeout applies.
- R10: Writes through ld_we are ignored while a transmission is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| local_addr | input | 16 | Address this node answers to |
| tmo_ticks | input | TMO_W | Receive stall limit in bit ticks, 0 disables |
| bit_tick | input | 1 | One pulse per bit time |
| rx_valid | input | 1 | Received byte strobe from codec |
| rx_byte | input | 8 | Received byte |
| pkt_valid | output | 1 | Accepted frame strobe |
| pkt_handler | output | 8 | Handler identifier of accepted frame |
| rd_idx | input | IDX_W | Buffer read index |
| rd_data | output | 8 | Buffer read data, one cycle latency |
| ld_we | input | 1 | Buffer write strobe for transmit loading |
| ld_idx | input | IDX_W | Buffer write index |
| ld_data | input | 8 | Buffer write data |
| send_req | input | 1 | Send command |
| send_ack | output | 1 | Send command answered |
| send_ok | output | 1 | Send command accepted |
| tx_valid | output | 1 | Byte offered to codec |
| tx_byte | output | 8 | Byte to transmit |
| tx_byte_done | input | 1 | Codec finished previous byte |
| tx_done | output | 1 | Transmission finished |
| tx_success | output | 1 | Status of finished transmission |

## Verification
The bench builds the block with PKT_LEN set to 6, so a frame is three header bytes plus three payload bytes. That makes each frame end and each address decision cheap to reach many times. With TMO_W at 8 and a limit of 4 ticks, the exact discard edge (3 versus 4 ticks) and the disabled setting can both be probed in a few dozen cycles. The codec model delays every byte-done by three cycles, so the full transmission stays open long enough to inject receive bytes, buffer writes and a second send request into it.

// File: rtl/pf_pkg.sv
package pf_pkg;
  typedef enum logic [1:0] {TX_IDLE, TX_FETCH, TX_LOAD, TX_WAIT} tx_state_e;
  localparam logic [15:0] PF_BCAST = 16'hFFFF;
  localparam int PF_HDR_LEN = 3;
endpackage

// File: rtl/pf_buf_ram.sv
module pf_buf_ram #(
  parameter int DEPTH = 30,
  parameter int AW    = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pf_rx_path.sv
module pf_rx_path
  import pf_pkg::*;
#(
  parameter int PKT_LEN = 30,
  parameter int IDX_W   = 5,
  parameter int TMO_W   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             rx_valid,
  input  logic [7:0]       rx_byte,
  input  logic             bit_tick,
  input  logic [TMO_W-1:0] tmo_ticks,
  input  logic [15:0]      local_addr,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data,
  output logic             busy,
  output logic             pkt_valid,
  output logic [7:0]       pkt_handler
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(PKT_LEN - 1);

  logic [IDX_W-1:0] cnt;
  logic [TMO_W-1:0] tmr;
  logic [7:0]       dst_hi, dst_lo, hdl;
  logic             take;
  logic [15:0]      dst;

  assign take    = enable & rx_valid;
  assign wr_en   = take;
  assign wr_idx  = cnt;
  assign wr_data = rx_byte;
  assign busy    = (cnt != '0);
  assign dst     = {dst_hi, dst_lo};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt         <= '0;
      tmr         <= '0;
      dst_hi      <= '0;
      dst_lo      <= '0;
      hdl         <= '0;
      pkt_valid   <= 1'b0;
      pkt_handler <= '0;
    end else begin
      pkt_valid <= 1'b0;
      if (take) begin
        tmr <= '0;
        if (cnt == IDX_W'(0)) dst_hi <= rx_byte;
        if (cnt == IDX_W'(1)) dst_lo <= rx_byte;
        if (cnt == IDX_W'(2)) hdl    <= rx_byte;
        if (cnt == LAST) begin
          cnt <= '0;
          if (dst == local_addr || dst == PF_BCAST) begin
            pkt_valid   <= 1'b1;
            pkt_handler <= hdl;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (busy && tmo_ticks != '0 && bit_tick) begin
        if (tmr == tmo_ticks - 1'b1) begin
          cnt <= '0;
          tmr <= '0;
        end else begin
          tmr <= tmr + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pf_tx_path.sv
module pf_tx_path
  import pf_pkg::*;
#(
  parameter int PKT_LEN = 30,
  parameter int IDX_W   = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             send_req,
  input  logic             rx_busy,
  input  logic             tx_byte_done,
  input  logic [7:0]       ram_q,
  output logic             active,
  output logic [IDX_W-1:0] rd_idx,
  output logic             send_ack,
  output logic             send_ok,
  output logic             tx_valid,
  output logic [7:0]       tx_byte,
  output logic             tx_done,
  output logic             tx_success
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(PKT_LEN - 1);

  tx_state_e        state;
  logic [IDX_W-1:0] idx;
  logic             accept;

  assign active = (state != TX_IDLE);
  assign rd_idx = idx;
  assign accept = send_req && (state == TX_IDLE) && !rx_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= TX_IDLE;
      idx        <= '0;
      send_ack   <= 1'b0;
      send_ok    <= 1'b0;
      tx_valid   <= 1'b0;
      tx_byte    <= '0;
      tx_done    <= 1'b0;
      tx_success <= 1'b0;
    end else begin
      send_ack <= send_req;
      tx_valid <= 1'b0;
      tx_done  <= 1'b0;
      if (send_req) send_ok <= accept;
      case (state)
        TX_IDLE: if (accept) begin
          state <= TX_FETCH;
          idx   <= '0;
        end
        TX_FETCH: state <= TX_LOAD;
        TX_LOAD: begin
          tx_byte  <= ram_q;
          tx_valid <= 1'b1;
          state    <= TX_WAIT;
        end
        TX_WAIT: if (tx_byte_done) begin
          if (idx == LAST) begin
            tx_done    <= 1'b1;
            tx_success <= 1'b1;
            state      <= TX_IDLE;
          end else begin
            idx   <= idx + 1'b1;
            state <= TX_FETCH;
          end
        end
        default: state <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pkt_framer.sv
module pkt_framer #(
  parameter int PKT_LEN = 30,
  parameter int TMO_W   = 16,
  localparam int IDX_W  = $clog2(PKT_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [15:0]      local_addr,
  input  logic [TMO_W-1:0] tmo_ticks,
  input  logic             bit_tick,
  input  logic             rx_valid,
  input  logic [7:0]       rx_byte,
  output logic             pkt_valid,
  output logic [7:0]       pkt_handler,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_data,
  input  logic             ld_we,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic [7:0]       ld_data,
  input  logic             send_req,
  output logic             send_ack,
  output logic             send_ok,
  output logic             tx_valid,
  output logic [7:0]       tx_byte,
  input  logic             tx_byte_done,
  output logic             tx_done,
  output logic             tx_success
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PKT_LEN - 1);

  logic             tx_active, rx_we, rx_busy, ld_ok, ram_we;
  logic [IDX_W-1:0] rx_idx, tx_idx, waddr, raddr;
  logic [7:0]       rx_wdata, wdata, ram_q;

  assign ld_ok   = ld_we & ~tx_active & (ld_idx <= LAST_IDX);
  assign ram_we  = rx_we | ld_ok;
  assign waddr   = rx_we ? rx_idx : ld_idx;
  assign wdata   = rx_we ? rx_wdata : ld_data;
  assign raddr   = tx_active ? tx_idx : rd_idx;
  assign rd_data = ram_q;

  pf_buf_ram #(.DEPTH(PKT_LEN), .AW(IDX_W)) u_ram (
    .clk(clk), .we(ram_we), .waddr(waddr), .wdata(wdata),
    .raddr(raddr), .rdata(ram_q)
  );

  pf_rx_path #(.PKT_LEN(PKT_LEN), .IDX_W(IDX_W), .TMO_W(TMO_W)) u_rx (
    .clk(clk), .rst(rst), .enable(~tx_active), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .bit_tick(bit_tick), .tmo_ticks(tmo_ticks),
    .local_addr(local_addr), .wr_en(rx_we), .wr_idx(rx_idx),
    .wr_data(rx_wdata), .busy(rx_busy), .pkt_valid(pkt_valid),
    .pkt_handler(pkt_handler)
  );

  pf_tx_path #(.PKT_LEN(PKT_LEN), .IDX_W(IDX_W)) u_tx (
    .clk(clk), .rst(rst), .send_req(send_req),
    .rx_busy(rx_busy | rx_valid), .tx_byte_done(tx_byte_done),
    .ram_q(ram_q), .active(tx_active), .rd_idx(tx_idx),
    .send_ack(send_ack), .send_ok(send_ok), .tx_valid(tx_valid),
    .tx_byte(tx_byte), .tx_done(tx_done), .tx_success(tx_success)
  );
endmodule

// File: rtl/pf_checker.sv
module pf_checker (
  input logic clk,
  input logic rst,
  input logic rx_valid,
  input logic pkt_valid,
  input logic send_req,
  input logic send_ack,
  input logic send_ok,
  input logic tx_valid,
  input logic tx_done,
  input logic tx_success
);
  p_ack_follows_req_r5: assert property (@(posedge clk) disable iff (rst)
    send_req |=> send_ack);

  p_ack_needs_req_r5: assert property (@(posedge clk) disable iff (rst)
    send_ack |-> $past(send_req));

  p_byte_single_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    tx_valid |=> !tx_valid);

  p_first_byte_timing_r6: assert property (@(posedge clk) disable iff (rst)
    (send_ack && send_ok) |=> ##1 tx_valid);

  p_done_success_r7: assert property (@(posedge clk) disable iff (rst)
    tx_done |-> tx_success);

  p_pkt_after_byte_r3: assert property (@(posedge clk) disable iff (rst)
    pkt_valid |-> $past(rx_valid));
endmodule

bind pkt_framer pf_checker u_chk (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .pkt_valid(pkt_valid),
  .send_req(send_req), .send_ack(send_ack), .send_ok(send_ok),
  .tx_valid(tx_valid), .tx_done(tx_done), .tx_success(tx_success)
);

// File: tb/sim_pkt_framer.sv
module sim_pkt_framer;
  localparam int CLK_PERIOD = 10;
  localparam int PLEN = 6;
  localparam int TW = 8;
  localparam int IW = $clog2(PLEN);
  localparam logic [15:0] MY_ADDR = 16'h1234;

  logic clk = 1'b0, rst = 1'b1;
  logic [15:0] local_addr = MY_ADDR;
  logic [TW-1:0] tmo_ticks = 8'd4;
  logic bit_tick = 0, rx_valid = 0, ld_we = 0, send_req = 0, tx_byte_done = 0;
  logic [7:0] rx_byte = 0, ld_data = 0;
  logic [IW-1:0] rd_idx = 0, ld_idx = 0;
  logic pkt_valid, send_ack, send_ok, tx_valid, tx_done, tx_success;
  logic [7:0] pkt_handler, rd_data, tx_byte;

  int checks = 0, fails = 0, pkt_seen = 0;
  bit reported = 0;
  logic [7:0] exp_hdl_q[$];
  logic [7:0] exp_tx_q[$];
  logic [7:0] loaded[PLEN];

  always #(CLK_PERIOD/2) clk = ~clk;

  pkt_framer #(.PKT_LEN(PLEN), .TMO_W(TW)) u0 (
    .clk(clk), .rst(rst), .local_addr(local_addr), .tmo_ticks(tmo_ticks),
    .bit_tick(bit_tick), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .pkt_valid(pkt_valid), .pkt_handler(pkt_handler), .rd_idx(rd_idx),
    .rd_data(rd_data), .ld_we(ld_we), .ld_idx(ld_idx), .ld_data(ld_data),
    .send_req(send_req), .send_ack(send_ack), .send_ok(send_ok),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_byte_done(tx_byte_done),
    .tx_done(tx_done), .tx_success(tx_success)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic rx_one(input logic [7:0] b);
    @(negedge clk); rx_valid = 1; rx_byte = b;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic rx_frame(input logic [7:0] ah, input logic [7:0] al, input logic [7:0] h,
                          input logic [7:0] p0, input logic [7:0] p1, input logic [7:0] p2);
    rx_one(ah); rx_one(al); rx_one(h); rx_one(p0); rx_one(p1); rx_one(p2);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bit_tick = 1;
      @(negedge clk); bit_tick = 0;
    end
  endtask

  task automatic rd_chk(input int idx, input logic [7:0] exp, input string req);
    @(negedge clk); rd_idx = IW'(idx);
    @(negedge clk); chk(rd_data === exp, req, rd_data, exp);
  endtask

  task automatic ld(input int idx, input logic [7:0] d);
    @(negedge clk); ld_we = 1; ld_idx = IW'(idx); ld_data = d;
    @(negedge clk); ld_we = 0;
  endtask

  task automatic do_send(input bit exp_ok, input string req);
    @(negedge clk); send_req = 1;
    @(negedge clk); send_req = 0;
    chk(send_ack === 1'b1, req, send_ack, 1);
    chk(send_ok === exp_ok, req, send_ok, exp_ok);
  endtask

  task automatic settle_pkts(input string req);
    repeat (3) @(negedge clk);
    chk(exp_hdl_q.size() == 0, req, exp_hdl_q.size(), 0);
  endtask

  // frame monitor: scoreboard of expected handler identifiers (R3, R4)
  initial forever begin
    @(negedge clk);
    if (!rst && pkt_valid) begin
      pkt_seen++;
      if (exp_hdl_q.size() == 0) chk(0, "R4 unexpected frame", pkt_handler, 0);
      else begin
        logic [7:0] e;
        e = exp_hdl_q.pop_front();
        chk(pkt_handler === e, "R3 handler", pkt_handler, e);
      end
    end
  end

  // codec model and transmit scoreboard (R6)
  initial forever begin
    @(negedge clk);
    if (!rst && tx_valid) begin
      if (exp_tx_q.size() == 0) chk(0, "R6 extra byte", tx_byte, 0);
      else begin
        logic [7:0] e;
        e = exp_tx_q.pop_front();
        chk(tx_byte === e, "R6 byte order", tx_byte, e);
      end
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        chk(tx_valid === 1'b0, "R6 waits for byte done", tx_valid, 0);
      end
      tx_byte_done = 1;
      @(negedge clk); tx_byte_done = 0;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hang expected completion");
    report();
  end

  initial begin
    int snap;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(pkt_valid === 0, "R1 pkt_valid", pkt_valid, 0);
    chk(send_ack === 0, "R1 send_ack", send_ack, 0);
    chk(tx_valid === 0, "R1 tx_valid", tx_valid, 0);
    chk(tx_done === 0, "R1 tx_done", tx_done, 0);

    // R3 local match, R2 storage
    exp_hdl_q.push_back(8'h07);
    rx_frame(8'h12, 8'h34, 8'h07, 8'hA1, 8'hA2, 8'hA3);
    settle_pkts("R3 local frame delivered");
    rd_chk(0, 8'h12, "R2 idx0"); rd_chk(2, 8'h07, "R2 idx2");
    rd_chk(3, 8'hA1, "R2 idx3"); rd_chk(5, 8'hA3, "R2 idx5");

    // R4 broadcast and mismatch
    exp_hdl_q.push_back(8'h09);
    rx_frame(8'hFF, 8'hFF, 8'h09, 8'h01, 8'h02, 8'h03);
    settle_pkts("R4 broadcast delivered");
    snap = pkt_seen;
    rx_frame(8'h12, 8'h35, 8'h05, 8'h01, 8'h02, 8'h03);
    repeat (3) @(negedge clk);
    chk(pkt_seen == snap, "R4 mismatch dropped", pkt_seen, snap);
    exp_hdl_q.push_back(8'h0B);
    rx_frame(8'h12, 8'h34, 8'h0B, 8'h11, 8'h22, 8'h33);
    settle_pkts("R4 framing after mismatch");

    // R9 timeout: full limit discards, one less keeps
    rx_one(8'h12); rx_one(8'h34);
    ticks(4);
    exp_hdl_q.push_back(8'h0C);
    rx_frame(8'h12, 8'h34, 8'h0C, 8'h44, 8'h55, 8'h66);
    settle_pkts("R9 discard at limit");
    rd_chk(1, 8'h34, "R9 restart at idx0");
    exp_hdl_q.push_back(8'h0D);
    rx_one(8'h12); rx_one(8'h34);
    ticks(3);
    rx_one(8'h0D); rx_one(8'h01); rx_one(8'h02); rx_one(8'h03);
    settle_pkts("R9 kept below limit");
    tmo_ticks = 0;
    exp_hdl_q.push_back(8'h0E);
    rx_one(8'h12); rx_one(8'h34);
    ticks(10);
    rx_one(8'h0E); rx_one(8'h01); rx_one(8'h02); rx_one(8'h03);
    settle_pkts("R9 zero disables");
    tmo_ticks = 8'd4;

    // R5 rejected while a receive frame is partial
    exp_hdl_q.push_back(8'h0F);
    rx_one(8'h12);
    do_send(0, "R5 busy receive");
    rx_one(8'h34); rx_one(8'h0F); rx_one(8'h01); rx_one(8'h02); rx_one(8'h03);
    settle_pkts("R5 frame intact after reject");

    // transmit
    for (int i = 0; i < PLEN; i++) begin
      loaded[i] = 8'h50 + 8'(i * 17);
      ld(i, loaded[i]);
      exp_tx_q.push_back(loaded[i]);
    end
    snap = pkt_seen;
    do_send(1, "R5 idle accept");
    do_send(0, "R5 busy transmit");
    rx_one(8'h12); rx_one(8'h34); rx_one(8'h10);
    ld(3, 8'h00);
    begin
      int guard = 0;
      while (tx_done !== 1'b1 && guard < 500) begin
        @(negedge clk); guard++;
      end
      chk(tx_done === 1'b1, "R7 done seen", tx_done, 1);
      chk(tx_success === 1'b1, "R7 success", tx_success, 1);
    end
    chk(exp_tx_q.size() == 0, "R6 all bytes sent", exp_tx_q.size(), 0);
    chk(pkt_seen == snap, "R8 no frame during transmit", pkt_seen, snap);
    for (int i = 0; i < PLEN; i++) rd_chk(i, loaded[i], (i == 3) ? "R10 load ignored" : "R8 buffer kept");
    exp_hdl_q.push_back(8'h21);
    rx_frame(8'h12, 8'h34, 8'h21, 8'h01, 8'h02, 8'h03);
    settle_pkts("R8 receive index stayed zero");
    report();
  end
endmodule